// File: doc/BRIEF.md
# Endpoint Interrupt Status Register

This block keeps the interrupt status bits of one endpoint of a USB device controller. A parameter selects the IN-endpoint or the OUT-endpoint variant. Strobes from the protocol engine and the DMA engine set the status bits, and each bit stays set until software clears it. Whether a strobe may set its bit depends on the endpoint's mode inputs: whether the endpoint is a control endpoint, whether internal DMA is on, whether scatter/gather descriptors are in use, and whether dedicated FIFO mode is selected.

Software sees the status and a mask of equal width through plain registered read outputs. It changes them through one write port that selects either the status register, which is write-1-to-clear, or the mask register, which is written directly. The block ANDs the status with the mask and ORs the result into one registered endpoint interrupt line.

Status bit layout, which the neighbouring logic decodes: bit 0 is transfer complete, bit 1 is endpoint disabled, bit 2 is bus error, bit 3 is timeout on the IN variant and SETUP done on the OUT variant, and bit 4 is OUT token while disabled, which exists on the OUT variant only.

Top module: `ep_irq_status`

## Requirements
- R1: While `rst` is high at a clock edge, `rd_status`, `rd_mask` and `irq` are all 0 after that edge.
- R2: With scatter/gather inactive (`sg_en`=0 or `dma_en`=0), a pulse on `ev_xfer_done` sets status bit 0. While scatter/gather is active (`dma_en`=1 and `sg_en`=1), `ev_xfer_done` has no effect.
- R3: While scatter/gather is active, `ev_desc_close` sets status bit 0 only when `desc_ioc` is 1 in the same cycle. While scatter/gather is inactive, `ev_desc_close` has no effect.
- R4: `ev_ep_disabled` sets status bit 1 in every mode and in both variants.
- R5: `ev_bus_err` sets status bit 2 only when `dma_en` is 1.
- R6: On the IN variant, `ev_timeout` sets status bit 3 only when `ctl_ep`=1, `fifo_ded`=1 and scatter/gather is inactive. On the OUT variant, `ev_timeout` has no effect.
- R7: On the OUT variant, `ev_setup_done` sets status bit 3 only when `ctl_ep`=1. On the IN variant, `ev_setup_done` has no effect.
- R8: On the OUT variant, `ev_out_tok_dis` sets status bit 4 only when `ctl_ep`=1. On the IN variant, bit 4 always reads 0.
- R9: A write with `wr_en`=1 and `wr_sel`=0 clears every status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R10: If a set event and a write-1-clear reach the same status bit in the same cycle, the bit is 1 after the edge.
- R11: A write with `wr_en`=1 and `wr_sel`=1 loads `wr_data` into the mask. `irq` equals the OR of `rd_status & rd_mask` at every edge, so it changes at the same edge as the status.
- R12: A set status bit stays set until a write-1-clear reaches it. A status bit changes from 0 to 1 only after a qualified set event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_ep | input | 1 | The endpoint is a control endpoint |
| dma_en | input | 1 | Internal DMA mode is on |
| sg_en | input | 1 | Scatter/gather descriptors are in use (effective only with dma_en) |
| fifo_ded | input | 1 | Dedicated FIFO mode is selected |
| ev_xfer_done | input | 1 | Programmed transfer finished on both the bus and the USB side |
| ev_desc_close | input | 1 | A DMA descriptor was closed |
| desc_ioc | input | 1 | The closed descriptor asks for an interrupt on completion |
| ev_ep_disabled | input | 1 | The endpoint was disabled on request |
| ev_bus_err | input | 1 | A system bus read or write failed during this endpoint's DMA |
| ev_timeout | input | 1 | Timeout seen on the last IN token |
| ev_setup_done | input | 1 | SETUP phase ended with no back-to-back SETUP |
| ev_out_tok_dis | input | 1 | An OUT token arrived before the endpoint was enabled |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects status (write-1-clear), 1 selects mask |
| wr_data | input | 5 | Write data |
| rd_status | output | 5 | Current status bits |
| rd_mask | output | 5 | Current mask bits |
| irq | output | 1 | Registered OR of the masked status bits |

## Verification
A wrong gating term in the qualification logic shows at `rd_status` one edge after the offending strobe: a bit that should have stayed 0 comes up, or an expected bit stays low. A broken sticky or clear path shows one edge after an idle cycle or a write. Because every result appears at the ports one cycle later, the bench sweeps every mode combination against every single event on both variants, clears the bits after each step, and compares the outputs against values it derives from the gating rules.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  parameter int unsigned EP_NBITS = 5;
  parameter int unsigned B_XFER   = 0;
  parameter int unsigned B_EPDIS  = 1;
  parameter int unsigned B_BUSERR = 2;
  parameter int unsigned B_PHASE  = 3;
  parameter int unsigned B_TOKDIS = 4;
  typedef logic [EP_NBITS-1:0] ep_vec_t;
endpackage

// File: rtl/ep_irq_qualify.sv
module ep_irq_qualify
  import ep_irq_pkg::*;
#(
  parameter bit IS_IN = 1'b1
) (
  input  logic    ctl_ep,
  input  logic    dma_en,
  input  logic    sg_en,
  input  logic    fifo_ded,
  input  logic    ev_xfer_done,
  input  logic    ev_desc_close,
  input  logic    desc_ioc,
  input  logic    ev_ep_disabled,
  input  logic    ev_bus_err,
  input  logic    ev_timeout,
  input  logic    ev_setup_done,
  input  logic    ev_out_tok_dis,
  output ep_vec_t set_vec
);
  logic sg_act;
  logic xfer_set;
  logic phase_set;
  logic tokdis_set;

  assign sg_act = dma_en & sg_en;

  always_comb begin
    if (sg_act) xfer_set = ev_desc_close & desc_ioc;
    else        xfer_set = ev_xfer_done;
  end

  generate
    if (IS_IN) begin : g_in
      assign phase_set  = ev_timeout & ctl_ep & fifo_ded & ~sg_act;
      assign tokdis_set = 1'b0;
    end else begin : g_out
      assign phase_set  = ev_setup_done & ctl_ep;
      assign tokdis_set = ev_out_tok_dis & ctl_ep;
    end
  endgenerate

  always_comb begin
    set_vec           = '0;
    set_vec[B_XFER]   = xfer_set;
    set_vec[B_EPDIS]  = ev_ep_disabled;
    set_vec[B_BUSERR] = ev_bus_err & dma_en;
    set_vec[B_PHASE]  = phase_set;
    set_vec[B_TOKDIS] = tokdis_set;
  end
endmodule

// File: rtl/ep_irq_bit.sv
module ep_irq_bit (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic sw_clr,
  output logic q,
  output logic d
);
  // a set wins over a clear arriving in the same cycle
  always_comb begin
    if (hw_set)      d = 1'b1;
    else if (sw_clr) d = 1'b0;
    else             d = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/ep_irq_mask.sv
module ep_irq_mask #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] d
);
  assign d = load ? din : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/ep_irq_status.sv
module ep_irq_status
  import ep_irq_pkg::*;
#(
  parameter bit IS_IN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_ep,
  input  logic                dma_en,
  input  logic                sg_en,
  input  logic                fifo_ded,
  input  logic                ev_xfer_done,
  input  logic                ev_desc_close,
  input  logic                desc_ioc,
  input  logic                ev_ep_disabled,
  input  logic                ev_bus_err,
  input  logic                ev_timeout,
  input  logic                ev_setup_done,
  input  logic                ev_out_tok_dis,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [EP_NBITS-1:0] wr_data,
  output logic [EP_NBITS-1:0] rd_status,
  output logic [EP_NBITS-1:0] rd_mask,
  output logic                irq
);
  ep_vec_t set_vec;
  ep_vec_t clr_vec;
  ep_vec_t stat_q;
  ep_vec_t stat_d;
  ep_vec_t mask_q;
  ep_vec_t mask_d;
  logic    irq_q;

  ep_irq_qualify #(.IS_IN(IS_IN)) u_qual (
    .ctl_ep        (ctl_ep),
    .dma_en        (dma_en),
    .sg_en         (sg_en),
    .fifo_ded      (fifo_ded),
    .ev_xfer_done  (ev_xfer_done),
    .ev_desc_close (ev_desc_close),
    .desc_ioc      (desc_ioc),
    .ev_ep_disabled(ev_ep_disabled),
    .ev_bus_err    (ev_bus_err),
    .ev_timeout    (ev_timeout),
    .ev_setup_done (ev_setup_done),
    .ev_out_tok_dis(ev_out_tok_dis),
    .set_vec       (set_vec)
  );

  assign clr_vec = (wr_en && !wr_sel) ? wr_data : '0;

  generate
    for (genvar i = 0; i < EP_NBITS; i++) begin : g_bit
      ep_irq_bit u_bit (
        .clk   (clk),
        .rst   (rst),
        .hw_set(set_vec[i]),
        .sw_clr(clr_vec[i]),
        .q     (stat_q[i]),
        .d     (stat_d[i])
      );
    end
  endgenerate

  ep_irq_mask #(.W(EP_NBITS)) u_mask (
    .clk (clk),
    .rst (rst),
    .load(wr_en & wr_sel),
    .din (wr_data),
    .q   (mask_q),
    .d   (mask_d)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_d & mask_d);
  end

  assign rd_status = stat_q;
  assign rd_mask   = mask_q;
  assign irq       = irq_q;
endmodule

// File: rtl/ep_irq_status_chk.sv
module ep_irq_status_chk
  import ep_irq_pkg::*;
#(
  parameter bit IS_IN = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                ctl_ep,
  input logic                dma_en,
  input logic                sg_en,
  input logic                fifo_ded,
  input logic                wr_en,
  input logic                wr_sel,
  input logic [EP_NBITS-1:0] wr_data,
  input logic [EP_NBITS-1:0] set_vec,
  input logic [EP_NBITS-1:0] rd_status,
  input logic [EP_NBITS-1:0] rd_mask,
  input logic                irq
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rd_status == '0 && rd_mask == '0 && !irq));

  // R11
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(rd_status & rd_mask));

  generate
    for (genvar i = 0; i < EP_NBITS; i++) begin : g_b
      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> rd_status[i]);
      // R12
      sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_status[i] && !(wr_en && !wr_sel && wr_data[i])) |=> rd_status[i]);
      // R12
      no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_status[i]) |-> $past(set_vec[i]));
      // R9
      w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && wr_data[i] && !set_vec[i]) |=> !rd_status[i]);
    end
    if (IS_IN) begin : g_in
      // R8
      in_bit4_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_status[B_TOKDIS]);
      // R6
      timeout_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_status[B_PHASE]) |-> $past(ctl_ep && fifo_ded && !(dma_en && sg_en)));
    end else begin : g_out
      // R7
      setup_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_status[B_PHASE]) |-> $past(ctl_ep));
    end
  endgenerate
endmodule

bind ep_irq_status ep_irq_status_chk #(.IS_IN(IS_IN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctl_ep   (ctl_ep),
  .dma_en   (dma_en),
  .sg_en    (sg_en),
  .fifo_ded (fifo_ded),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .set_vec  (set_vec),
  .rd_status(rd_status),
  .rd_mask  (rd_mask),
  .irq      (irq)
);

// File: tb/ep_irq_status_tb.sv
module ep_irq_status_tb;
  logic clk = 1'b0;
  logic rst;
  logic ctl_ep, dma_en, sg_en, fifo_ded;
  logic ev_xfer_done, ev_desc_close, desc_ioc, ev_ep_disabled;
  logic ev_bus_err, ev_timeout, ev_setup_done, ev_out_tok_dis;
  logic wr_en, wr_sel;
  logic [4:0] wr_data;
  logic [4:0] st_i, mk_i, st_o, mk_o;
  logic irq_i, irq_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ep_irq_status #(.IS_IN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ctl_ep(ctl_ep), .dma_en(dma_en), .sg_en(sg_en),
    .fifo_ded(fifo_ded), .ev_xfer_done(ev_xfer_done), .ev_desc_close(ev_desc_close),
    .desc_ioc(desc_ioc), .ev_ep_disabled(ev_ep_disabled), .ev_bus_err(ev_bus_err),
    .ev_timeout(ev_timeout), .ev_setup_done(ev_setup_done),
    .ev_out_tok_dis(ev_out_tok_dis), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_status(st_i), .rd_mask(mk_i), .irq(irq_i));

  ep_irq_status #(.IS_IN(1'b0)) u_dut_out (
    .clk(clk), .rst(rst), .ctl_ep(ctl_ep), .dma_en(dma_en), .sg_en(sg_en),
    .fifo_ded(fifo_ded), .ev_xfer_done(ev_xfer_done), .ev_desc_close(ev_desc_close),
    .desc_ioc(desc_ioc), .ev_ep_disabled(ev_ep_disabled), .ev_bus_err(ev_bus_err),
    .ev_timeout(ev_timeout), .ev_setup_done(ev_setup_done),
    .ev_out_tok_dis(ev_out_tok_dis), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_status(st_o), .rd_mask(mk_o), .irq(irq_o));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_ev(int ev, logic v);
    case (ev)
      0: ev_xfer_done = v;
      1: begin ev_desc_close = v; desc_ioc = v; end
      2: ev_desc_close = v;
      3: ev_ep_disabled = v;
      4: ev_bus_err = v;
      5: ev_timeout = v;
      6: ev_setup_done = v;
      default: ev_out_tok_dis = v;
    endcase
  endtask

  function automatic logic [4:0] exp_set(bit is_in, bit c, bit d, bit s, bit f, int ev);
    bit sga;
    logic [4:0] r;
    sga = d & s;
    r = 5'h0;
    case (ev)
      0: r[0] = !sga;
      1: r[0] = sga;
      2: r[0] = 1'b0;
      3: r[1] = 1'b1;
      4: r[2] = d;
      5: r[3] = is_in & c & f & !sga;
      6: r[3] = !is_in & c;
      default: r[4] = !is_in & c;
    endcase
    return r;
  endfunction

  function automatic string ev_tag(int ev);
    case (ev)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic wr(bit sel, logic [4:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step();
    wr_en = 1'b0; wr_data = 5'h0;
  endtask

  initial begin
    rst = 1'b1;
    {ctl_ep, dma_en, sg_en, fifo_ded} = 4'h0;
    {ev_xfer_done, ev_desc_close, desc_ioc, ev_ep_disabled} = 4'h0;
    {ev_bus_err, ev_timeout, ev_setup_done, ev_out_tok_dis} = 4'h0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 5'h0;
    @(negedge clk);
    step();
    // R1 reset state
    chk("R1 in status", st_i, 0);
    chk("R1 out status", st_o, 0);
    chk("R1 in mask", mk_i, 0);
    chk("R1 out irq", irq_o, 0);
    rst = 1'b0;
    step();

    wr(1'b1, 5'h1F);
    chk("R11 mask load", mk_i, 5'h1F);

    // sweep every mode against every single event, both variants
    for (int m = 0; m < 16; m++) begin
      for (int ev = 0; ev < 8; ev++) begin
        logic [4:0] ei, eo;
        ctl_ep = m[0]; dma_en = m[1]; sg_en = m[2]; fifo_ded = m[3];
        ei = exp_set(1'b1, m[0], m[1], m[2], m[3], ev);
        eo = exp_set(1'b0, m[0], m[1], m[2], m[3], ev);
        drive_ev(ev, 1'b1);
        step();
        drive_ev(ev, 1'b0);
        chk({ev_tag(ev), " in status"}, st_i, ei);
        chk({ev_tag(ev), " out status"}, st_o, eo);
        chk("R11 in irq", irq_i, int'(ei != 0));
        chk("R11 out irq", irq_o, int'(eo != 0));
        step();
        chk("R12 in hold", st_i, ei);
        wr(1'b0, 5'h1F);
        chk("R9 in clear", st_i, 0);
        chk("R9 out clear", st_o, 0);
      end
    end

    // R9 write of 0 leaves bits unchanged
    {ctl_ep, dma_en, sg_en, fifo_ded} = 4'h0;
    ev_ep_disabled = 1'b1; ev_xfer_done = 1'b1;
    step();
    ev_ep_disabled = 1'b0; ev_xfer_done = 1'b0;
    wr(1'b0, 5'h00);
    chk("R9 write zero", st_i, 5'h03);
    wr(1'b0, 5'h01);
    chk("R9 partial clear", st_i, 5'h02);

    // R10 set and clear collide on bit 1
    ev_ep_disabled = 1'b1;
    wr(1'b0, 5'h02);
    ev_ep_disabled = 1'b0;
    chk("R10 set wins", st_i, 5'h02);

    // R11 mask gates irq
    wr(1'b1, 5'h01);
    chk("R11 masked irq", irq_i, 0);
    wr(1'b1, 5'h02);
    chk("R11 unmasked irq", irq_i, 1);
    wr(1'b0, 5'h02);
    chk("R11 irq drop", irq_i, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule